// File: doc/BRIEF.md
# Double-Buffered Pulse-Width Modulator

This block drives one pulse-width modulated output from its own counting chain. A clock prescaler (divide by 1, 4 or 16) advances a 2-bit sub-count. When the sub-count wraps, an 8-bit timer advances. Together the timer and the sub-count form a 10-bit time base. When the timer reaches the programmed period value and its sub-count is at its top, the chain restarts from zero. That restart begins a new PWM cycle.

The high time is a 10-bit value supplied as an 8-bit upper part and a 2-bit lower part. The live value can change at any moment, but the comparator only sees a shadow copy. The shadow copy is refreshed at each cycle boundary and when the block is switched on. This means a mid-cycle change never produces a runt or stretched pulse. A high time of zero keeps the output low. A high time that the time base can never reach keeps the output high. A one-clock strobe marks every restart of the timer.

Top module: `pwm10_gen`

## Requirements
- R1: While `en` is low, on the clock after it is sampled low, `pwm_out` and `period_end` are 0 and `tmr_val` is 0.
- R2: With `en` held high, the time base advances once per prescaler tick. `tmr_val` in the j-th clock after a cycle start equals floor(j / prescale) / 4. A cycle lasts exactly (period + 1) × 4 × prescale clocks.
- R3: `pre_sel` picks the prescale: 2'b00 gives 1, 2'b01 gives 4, 2'b10 and 2'b11 give 16.
- R4: For a high time D with 0 < D < 4 × (period + 1), `pwm_out` is high for exactly D × prescale clocks at the start of each cycle, then low for the rest of the cycle.
- R5: A high time of 0 keeps `pwm_out` low for the whole cycle.
- R6: A high time of 4 × (period + 1) or more keeps `pwm_out` high for the whole cycle.
- R7: A change to the high time takes effect only from the next cycle start. This includes a change presented in the last clock before the boundary, which the new cycle takes.
- R8: `period_end` is high for exactly one clock, the first clock of every cycle that follows a timer restart. In that clock, `pwm_out` is already at its starting level.
- R9: When `en` rises, the first cycle starts on the next clock. It uses the high time present at that edge, whatever an earlier run left in the shadow copy. No `period_end` is produced for this first cycle.
- R10: The high time is {`duty_hi`, `duty_lo`}, with `duty_hi` as bits 9:2 and `duty_lo` as bits 1:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Run enable; low clears the counting chain and the output |
| period | input | 8 | Timer value at which the cycle ends |
| duty_hi | input | 8 | Upper eight bits of the high time |
| duty_lo | input | 2 | Lower two bits of the high time |
| pre_sel | input | 2 | Prescale select (1, 4, 16, 16) |
| pwm_out | output | 1 | Modulated output |
| period_end | output | 1 | One-clock strobe after each timer restart |
| tmr_val | output | 8 | Current timer value |

## Verification
The risky coincidence is between a new high time arriving and the cycle boundary that loads the shadow copy. Both can fall in the same clock.

The bench provokes this by changing the high time in the last clock of a cycle, and separately at mid-cycle. It then expects the next cycle to use the new value in the first case, and the old value to finish the current cycle in the second.

A second coincidence is between the output set and a clear compare at the top of the time base. The bench reaches this by sweeping high times across 4 × (period + 1) − 1, 4 × (period + 1) and beyond. Every clock of every cycle is then compared against the arithmetic high count and the expected timer value.

// File: rtl/pwm10_pkg.sv
package pwm10_pkg;

   // Width of the sub-count below the timer.
   localparam int unsigned SUB_BITS = 2;

   // Log2 of the prescale for a select code, capped at cap_log.
   function automatic int unsigned pre_log2(input logic [1:0] sel, input int unsigned cap_log);
      int unsigned s;
      s = 2 * int'(sel);
      if (s > cap_log) s = cap_log;
      return s;
   endfunction

endpackage

// File: rtl/pwm10_prescaler.sv
module pwm10_prescaler
   import pwm10_pkg::*;
#(
   parameter int unsigned PRE_LOG_MAX = 4
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       run,
   input  logic [1:0] sel,
   output logic       tick
);

   localparam int unsigned PC_W = (PRE_LOG_MAX == 0) ? 1 : PRE_LOG_MAX;

   generate
      if (PRE_LOG_MAX > 8 || (PRE_LOG_MAX % 2) != 0) begin : g_bad_cfg
         $error("pwm10_prescaler: PRE_LOG_MAX must be even and at most 8");
      end

      if (PRE_LOG_MAX == 0) begin : g_direct
         // Every clock is a tick; no divider is built.
         assign tick = run;
      end else begin : g_divider
         logic [PC_W-1:0] pc_q;
         logic [PC_W:0]   lim_full;
         logic [PC_W-1:0] lim_m1;

         always_comb begin
            lim_full = (PC_W+1)'(1) << pre_log2(sel, PRE_LOG_MAX);
            lim_m1   = PC_W'(lim_full - (PC_W+1)'(1));
         end

         // A comparison by >= lets the divider recover when the select shrinks.
         assign tick = run && (pc_q >= lim_m1);

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       pc_q <= '0;
            else if (!run)    pc_q <= '0;
            else if (tick)    pc_q <= '0;
            else              pc_q <= pc_q + PC_W'(1);
         end

         // R3: between ticks the divider steps by one each clock.
         p_div_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (run && !tick) |=> (pc_q == $past(pc_q) + PC_W'(1)));
      end
   endgenerate

endmodule

// File: rtl/pwm10_timebase.sv
module pwm10_timebase #(
   parameter int unsigned TMR_W = 8,
   parameter int unsigned SUB_W = 2
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   run,
   input  logic                   tick,
   input  logic [TMR_W-1:0]       period,
   output logic [TMR_W-1:0]       tmr,
   output logic                   wrap,
   output logic [TMR_W+SUB_W-1:0] base_next
);

   localparam int unsigned BASE_W = TMR_W + SUB_W;

   generate
      if (TMR_W < 2 || SUB_W < 1) begin : g_bad_cfg
         $error("pwm10_timebase: TMR_W must be >= 2 and SUB_W >= 1");
      end
   endgenerate

   logic [BASE_W-1:0] base_q;
   logic [SUB_W-1:0]  sub;

   assign tmr = base_q[BASE_W-1:SUB_W];
   assign sub = base_q[SUB_W-1:0];

   // Restart when the timer sits on the period value and the sub-count is full.
   assign wrap      = tick && (tmr == period) && (sub == {SUB_W{1'b1}});
   assign base_next = wrap ? '0 : (base_q + BASE_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     base_q <= '0;
      else if (!run)  base_q <= '0;
      else if (tick)  base_q <= base_next;
   end

   // R2: the time base moves only on a prescaler tick.
   p_hold_between_ticks_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !tick) |=> $stable(base_q));

   // R2: a restart returns the whole time base to zero.
   p_wrap_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (run && wrap) |=> (base_q == '0));

endmodule

// File: rtl/pwm10_duty.sv
module pwm10_duty #(
   parameter int unsigned DUTY_W = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              start,
   input  logic              wrap,
   input  logic              tick,
   input  logic [DUTY_W-1:0] base_next,
   input  logic [DUTY_W-1:0] duty,
   output logic              pwm_out
);

   logic [DUTY_W-1:0] shadow_q;
   logic              load;
   logic              clr;

   assign load = start || wrap;
   // The output drops on the tick that moves the time base onto the shadow value.
   assign clr  = tick && !wrap && (base_next == shadow_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     shadow_q <= '0;
      else if (load)  shadow_q <= duty;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      pwm_out <= 1'b0;
      else if (!en)    pwm_out <= 1'b0;
      else if (load)   pwm_out <= (duty != '0);
      else if (clr)    pwm_out <= 1'b0;
   end

   // R7: outside a boundary the shadow copy keeps its value.
   p_shadow_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> $stable(shadow_q));

   // R5: a zero shadow value never coexists with a high output.
   p_zero_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (shadow_q == '0) |-> !pwm_out);

   // R8: after a restart the output level reflects the new shadow value.
   p_restart_level_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (en && wrap) |=> (pwm_out == (shadow_q != '0)));

   // R4: while running, the output only falls on a prescaler tick.
   p_fall_on_tick_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(pwm_out) && $past(en)) |-> $past(tick));

endmodule

// File: rtl/pwm10_gen.sv
module pwm10_gen
   import pwm10_pkg::*;
#(
   parameter int unsigned TMR_W       = 8,
   parameter int unsigned PRE_LOG_MAX = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic [TMR_W-1:0] period,
   input  logic [TMR_W-1:0] duty_hi,
   input  logic [SUB_BITS-1:0] duty_lo,
   input  logic [1:0]       pre_sel,
   output logic             pwm_out,
   output logic             period_end,
   output logic [TMR_W-1:0] tmr_val
);

   localparam int unsigned DUTY_W = TMR_W + SUB_BITS;

   logic              en_q;
   logic              start;
   logic              run;
   logic              tick;
   logic              wrap;
   logic [DUTY_W-1:0] base_next;
   logic [DUTY_W-1:0] duty;

   assign duty  = {duty_hi, duty_lo};
   assign start = en && !en_q;
   assign run   = en && en_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q       <= 1'b0;
         period_end <= 1'b0;
      end else begin
         en_q       <= en;
         period_end <= run && wrap;
      end
   end

   pwm10_prescaler #(
      .PRE_LOG_MAX (PRE_LOG_MAX)
   ) u_pre (
      .clk  (clk),
      .rst_n(rst_n),
      .run  (run),
      .sel  (pre_sel),
      .tick (tick)
   );

   pwm10_timebase #(
      .TMR_W(TMR_W),
      .SUB_W(SUB_BITS)
   ) u_tb (
      .clk      (clk),
      .rst_n    (rst_n),
      .run      (run),
      .tick     (tick),
      .period   (period),
      .tmr      (tmr_val),
      .wrap     (wrap),
      .base_next(base_next)
   );

   pwm10_duty #(
      .DUTY_W(DUTY_W)
   ) u_duty (
      .clk      (clk),
      .rst_n    (rst_n),
      .en       (en),
      .start    (start),
      .wrap     (wrap),
      .tick     (tick),
      .base_next(base_next),
      .duty     (duty),
      .pwm_out  (pwm_out)
   );

   // R1: one clock after the enable is seen low, everything is quiet.
   p_off_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> (!pwm_out && !period_end && (tmr_val == '0)));

   // R8: the restart strobe lasts a single clock.
   p_strobe_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
      period_end |=> !period_end);

   // R9: the first clock after enable is a cycle start without a strobe.
   p_first_no_strobe_r9: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> !period_end);

endmodule

// File: tb/pwm10_gen_tb.sv
module pwm10_gen_tb;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       en = 1'b0;
   logic [7:0] period = '0;
   logic [7:0] duty_hi = '0;
   logic [1:0] duty_lo = '0;
   logic [1:0] pre_sel = '0;
   logic       pwm_out;
   logic       period_end;
   logic [7:0] tmr_val;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   pwm10_gen u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .en        (en),
      .period    (period),
      .duty_hi   (duty_hi),
      .duty_lo   (duty_lo),
      .pre_sel   (pre_sel),
      .pwm_out   (pwm_out),
      .period_end(period_end),
      .tmr_val   (tmr_val)
   );

   task automatic check(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         if (errors < 20)
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic int pre_of(input int sel);
      return (sel == 0) ? 1 : (sel == 1) ? 4 : 16;
   endfunction

   function automatic int high_clocks(input int d, input int p, input int pre);
      if (d == 0) return 0;                       // R5
      if (d >= 4 * (p + 1)) return 4 * (p + 1) * pre; // R6
      return d * pre;                             // R4
   endfunction

   task automatic set_duty(input int d);
      duty_hi = 8'(d >> 2);  // R10: bits 9:2
      duty_lo = 2'(d & 3);   // R10: bits 1:0
   endtask

   // Runs nper cycles; at sample chg_j of the first cycle the high time becomes d2.
   task automatic run_case(input int p, input int d1, input int sel, input int nper,
                           input int chg_j, input int d2);
      int pre, len, dd;
      @(negedge clk);
      en = 1'b0;
      @(negedge clk);
      check("R1 out", pwm_out, 0);
      check("R1 tmr", tmr_val, 0);
      period  = 8'(p);
      pre_sel = 2'(sel);
      set_duty(d1);
      en = 1'b1;
      pre = pre_of(sel);
      len = (p + 1) * 4 * pre;
      for (int c = 0; c < nper; c++) begin
         dd = (c == 0 || chg_j < 0) ? d1 : d2;
         for (int j = 0; j < len; j++) begin
            @(negedge clk);
            check((c == 0) ? "R9 out" : (chg_j >= 0 ? "R7 out" : "R4 out"),
                  pwm_out, (j < high_clocks(dd, p, pre)) ? 1 : 0);
            check("R8 strobe", period_end, (c > 0 && j == 0) ? 1 : 0);
            check("R2 tmr", tmr_val, (j / pre) / 4);
            if (c == 0 && j == chg_j) set_duty(d2);
         end
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check("R1 reset out", pwm_out, 0);
      check("R1 reset strobe", period_end, 0);
      rst_n = 1'b1;
      // R2 R3 R4 R5 R6 R10: sweep of prescales, periods and high times.
      for (int sel = 0; sel < 4; sel++) begin
         for (int pi = 0; pi < 3; pi++) begin
            automatic int p = (pi == 0) ? 0 : (pi == 1) ? 1 : 3;
            automatic int top = 4 * (p + 1);
            int dl[10];
            dl = '{0, 1, 2, 3, 5, top - 1, top, top + 1, 1023, top / 2 + 1};
            foreach (dl[k]) run_case(p, dl[k], sel, 2, -1, 0);
         end
      end
      // R7: change mid-cycle, then in the last clock before the boundary.
      run_case(3, 6, 1, 2, 32, 13);
      run_case(3, 6, 1, 2, 63, 13);
      run_case(1, 2, 0, 2, 7, 0);
      run_case(1, 0, 2, 2, 127, 1023);
      // R9: shadow left at 1023 above; a new run must use its own value.
      run_case(2, 3, 0, 2, -1, 0);
      @(negedge clk);
      en = 1'b0;
      @(negedge clk);
      check("R1 off strobe", period_end, 0);
      check("R1 off out", pwm_out, 0);
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #(150000 * 4);
      if (!done) begin
         errors++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule